// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers interrupt requests from a set of external sources, holds each as a pending bit, and routes them to a few processor contexts. Each context has one interrupt output line. Software sets a priority for each source, and for each context it sets an enable vector and a threshold. A context's line is high while at least one source is pending, is enabled for that context, and has a priority strictly above that context's threshold.

The handler reads the context's claim register. The read returns the best eligible source and clears that source's pending bit. The source then stays in service, and does not pend again, until software writes the same ID back to the same register. Each source can be set to level-high or rising-edge capture.

Access goes through a simple synchronous register bus. There are separate read and write strobes, and read data is registered. Source ID 0 is reserved. It never pends, and a claim that finds nothing eligible returns 0.

Top module: `intc_platform`

## Requirements
- R1: After reset, every priority, enable, threshold and trigger-mode field is 0, no source is pending, all interrupt outputs are low, and a claim read returns 0.
- R2: The priority of source ID sits at byte offset 4*ID and holds 3 bits. Upper bits read 0. The word for ID 0 always reads 0 and ignores writes.
- R3: The pending bits read as 32-bit words starting at offset 0x1000, with bit (ID mod 32) of word (ID/32). A source pends even when no context enables it. Writes to this word have no effect.
- R4: The enable vector of context c starts at offset 0x2000 + 0x80*c, one bit per source, with the same bit layout as pending. Bit 0 reads 0.
- R5: A context's output is high only when some source is pending, is enabled for that context, and has a priority strictly greater than that context's threshold. The threshold is 3 bits at offset 0x200000 + 0x1000*c. This means priority 0 never interrupts, and a threshold of 7 masks everything.
- R6: Among eligible sources, the highest priority wins, and a tie goes to the lowest ID.
- R7: A read of the claim register at offset 0x200004 + 0x1000*c returns the winning ID for context c and clears that source's pending bit. When nothing is eligible the read returns 0.
- R8: A level-mode source that has been claimed does not pend again until its ID is written back to the claim register. If its request is still high after that write, it pends again.
- R9: An edge-mode source pends only on a rising edge of its request. While it is in service, any number of rising edges are held as one deferred event, which pends once when the source is completed.
- R10: The trigger-mode word at offset 0x1080 holds one bit per source, in the same layout as pending: 1 means rising-edge, 0 means level-high. Bit 0 reads 0.
- R11: Writing an ID to a claim register completes that source only if the source is in service. A write of 0, or of an ID that is not in service, has no effect.
- R12: Each context keeps its own enable vector and threshold. A source routed to one context neither raises nor is claimable by another context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Source request lines; bit 0 is ignored |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a claim has its side effect in this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read strobe |
| irq_o | output | N_CTX | One interrupt line per context |

## Verification
A request on a source line is captured at the next clock edge. The pending bit and the interrupt line it can raise are therefore visible one cycle after the request changes. Register writes take effect at the edge that samples them, so the interrupt outputs reflect a new threshold or enable in the following cycle. Claim and ordinary read data appear one cycle after the read strobe, and the pending bit clears in that same cycle. The bench drives every stimulus on the falling edge and samples one falling edge after the rising edge that acts on it. It adds extra idle cycles wherever a check must show that something did not happen.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DEF_N_SRC  = 32;
    localparam int DEF_N_CTX  = 2;
    localparam int DEF_PRIO_W = 3;
    localparam int DEF_ADDR_W = 22;
    localparam int DATA_W     = 32;

    // Address map anchors (byte offsets)
    localparam logic [31:0] OFS_PRIO   = 32'h0000_0000;
    localparam logic [31:0] OFS_PEND   = 32'h0000_1000;
    localparam logic [31:0] OFS_TRIG   = 32'h0000_1080;
    localparam logic [31:0] OFS_EN     = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] OFS_CTL    = 32'h0020_0000;
    localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;
    localparam logic [31:0] CTL_THR    = 32'h0000_0000;
    localparam logic [31:0] CTL_CLAIM  = 32'h0000_0004;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_TRIG,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [15:0] idx;
        logic [7:0]  ctx;
    } reg_sel_t;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    function automatic int words_for(input int n);
        return (n + 31) / 32;
    endfunction

endpackage

// File: rtl/intc_gateway.sv
module intc_gateway (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic edge_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o
);
    import intc_pkg::*;

    logic prev_q, pend_q, busy_q, defer_q;
    logic rise, req;
    trig_e mode;

    assign mode = trig_e'(edge_i);
    assign rise = src_i & ~prev_q;
    assign req  = (mode == TRIG_EDGE) ? rise : src_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            busy_q  <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            prev_q <= src_i;
            if (claim_i) begin
                pend_q  <= 1'b0;
                busy_q  <= 1'b1;
                defer_q <= (mode == TRIG_EDGE) & rise;
            end else if (complete_i && busy_q) begin
                busy_q  <= 1'b0;
                defer_q <= 1'b0;
                if (mode == TRIG_EDGE)
                    pend_q <= defer_q | rise;
            end else if (busy_q) begin
                if (mode == TRIG_EDGE && rise)
                    defer_q <= 1'b1;
            end else if (req) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign pend_o = pend_q;

    // R8: a source in service never shows as pending
    a_r8_no_pend_in_service: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !pend_q);

    // R7: claim clears pending and enters service
    a_r7_claim_clears: assert property (@(posedge clk) disable iff (rst)
        claim_i |=> (!pend_q && busy_q));

    // R11: a completion for a source not in service changes nothing
    a_r11_stray_complete: assert property (@(posedge clk) disable iff (rst)
        (complete_i && !busy_q && !claim_i) |=> !busy_q);

    // R9: a deferred edge exists only while in service
    a_r9_defer_in_service: assert property (@(posedge clk) disable iff (rst)
        defer_q |-> busy_q);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N_SRC  = intc_pkg::DEF_N_SRC,
    parameter int PRIO_W = intc_pkg::DEF_PRIO_W,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [N_SRC-1:0]  en_i,
    input  logic [PRIO_W-1:0] prio_i [N_SRC],
    input  logic [PRIO_W-1:0] thr_i,
    output logic [ID_W-1:0]   id_o,
    output logic              irq_o
);
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // Ascending scan with strict compare: ties keep the lower ID,
    // and starting from the threshold enforces priority > threshold.
    always_comb begin
        best_p  = thr_i;
        best_id = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[s] > best_p)) begin
                best_p  = prio_i[s];
                best_id = ID_W'(s);
            end
        end
    end

    assign id_o  = best_id;
    assign irq_o = (best_id != '0);

    // R5: the winner is pending, enabled and above threshold
    a_r5_winner_eligible: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_i[id_o] && en_i[id_o] && (prio_i[id_o] > thr_i)));

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank #(
    parameter int N_SRC  = intc_pkg::DEF_N_SRC,
    parameter int N_CTX  = intc_pkg::DEF_N_CTX,
    parameter int PRIO_W = intc_pkg::DEF_PRIO_W,
    parameter int ADDR_W = intc_pkg::DEF_ADDR_W,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [ID_W-1:0]   best_id_i [N_CTX],
    output logic [PRIO_W-1:0] prio_o [N_SRC],
    output logic [N_SRC-1:0]  en_o [N_CTX],
    output logic [PRIO_W-1:0] thr_o [N_CTX],
    output logic [N_SRC-1:0]  edge_o,
    output logic [N_SRC-1:0]  claim_o,
    output logic [N_SRC-1:0]  complete_o
);
    import intc_pkg::*;

    localparam int WORDS = words_for(N_SRC);

    logic [PRIO_W-1:0] prio_q [N_SRC];
    logic [N_SRC-1:0]  en_q [N_CTX];
    logic [PRIO_W-1:0] thr_q [N_CTX];
    logic [N_SRC-1:0]  trig_q;
    logic [31:0]       rdata_q;
    logic [31:0]       rd_word;
    reg_sel_t          sel;

    function automatic logic [31:0] word_of(input logic [N_SRC-1:0] v, input logic [15:0] w);
        logic [31:0] r;
        r = '0;
        for (int s = 0; s < N_SRC; s++)
            if (16'(s / 32) == w)
                r[s % 32] = v[s];
        return r;
    endfunction

    // Address decode
    always_comb begin
        logic [31:0] a, rel, off;
        a   = 32'(addr_i) & ~32'h3;
        rel = '0;
        off = '0;
        sel.kind = RG_NONE;
        sel.idx  = '0;
        sel.ctx  = '0;
        if (a < OFS_PRIO + 32'(4 * N_SRC)) begin
            sel.kind = RG_PRIO;
            sel.idx  = 16'((a - OFS_PRIO) >> 2);
        end else if (a >= OFS_PEND && a < OFS_PEND + 32'(4 * WORDS)) begin
            sel.kind = RG_PEND;
            sel.idx  = 16'((a - OFS_PEND) >> 2);
        end else if (a >= OFS_TRIG && a < OFS_TRIG + 32'(4 * WORDS)) begin
            sel.kind = RG_TRIG;
            sel.idx  = 16'((a - OFS_TRIG) >> 2);
        end else if (a >= OFS_EN && a < OFS_EN + EN_STRIDE * 32'(N_CTX)) begin
            rel = a - OFS_EN;
            off = rel % EN_STRIDE;
            if (off < 32'(4 * WORDS)) begin
                sel.kind = RG_EN;
                sel.ctx  = 8'(rel / EN_STRIDE);
                sel.idx  = 16'(off >> 2);
            end
        end else if (a >= OFS_CTL && a < OFS_CTL + CTL_STRIDE * 32'(N_CTX)) begin
            rel = a - OFS_CTL;
            off = rel % CTL_STRIDE;
            sel.ctx = 8'(rel / CTL_STRIDE);
            if (off == CTL_THR)
                sel.kind = RG_THR;
            else if (off == CTL_CLAIM)
                sel.kind = RG_CLAIM;
        end
    end

    // Claim and completion strobes toward the gateways
    always_comb begin
        claim_o    = '0;
        complete_o = '0;
        if (sel.kind == RG_CLAIM) begin
            for (int c = 0; c < N_CTX; c++) begin
                if (sel.ctx == 8'(c) && rd_i) begin
                    for (int s = 1; s < N_SRC; s++)
                        if (best_id_i[c] == ID_W'(s))
                            claim_o[s] = 1'b1;
                end
            end
            if (wr_i) begin
                for (int s = 1; s < N_SRC; s++)
                    if (wdata_i == 32'(s))
                        complete_o[s] = 1'b1;
            end
        end
    end

    // Read mux
    always_comb begin
        rd_word = '0;
        unique case (sel.kind)
            RG_PRIO: begin
                for (int s = 0; s < N_SRC; s++)
                    if (sel.idx == 16'(s))
                        rd_word = 32'(prio_q[s]);
            end
            RG_PEND: rd_word = word_of(pend_i, sel.idx);
            RG_TRIG: rd_word = word_of(trig_q, sel.idx);
            RG_EN: begin
                for (int c = 0; c < N_CTX; c++)
                    if (sel.ctx == 8'(c))
                        rd_word = word_of(en_q[c], sel.idx);
            end
            RG_THR: begin
                for (int c = 0; c < N_CTX; c++)
                    if (sel.ctx == 8'(c))
                        rd_word = 32'(thr_q[c]);
            end
            RG_CLAIM: begin
                for (int c = 0; c < N_CTX; c++)
                    if (sel.ctx == 8'(c))
                        rd_word = 32'(best_id_i[c]);
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SRC; s++)
                prio_q[s] <= '0;
            for (int c = 0; c < N_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
            trig_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_i) begin
                unique case (sel.kind)
                    RG_PRIO: begin
                        for (int s = 1; s < N_SRC; s++)
                            if (sel.idx == 16'(s))
                                prio_q[s] <= wdata_i[PRIO_W-1:0];
                    end
                    RG_TRIG: begin
                        for (int s = 1; s < N_SRC; s++)
                            if (16'(s / 32) == sel.idx)
                                trig_q[s] <= wdata_i[s % 32];
                    end
                    RG_EN: begin
                        for (int c = 0; c < N_CTX; c++)
                            if (sel.ctx == 8'(c))
                                for (int s = 1; s < N_SRC; s++)
                                    if (16'(s / 32) == sel.idx)
                                        en_q[c][s] <= wdata_i[s % 32];
                    end
                    RG_THR: begin
                        for (int c = 0; c < N_CTX; c++)
                            if (sel.ctx == 8'(c))
                                thr_q[c] <= wdata_i[PRIO_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (rd_i)
                rdata_q <= rd_word;
        end
    end

    assign rdata_o = rdata_q;
    assign prio_o  = prio_q;
    assign en_o    = en_q;
    assign thr_o   = thr_q;
    assign edge_o  = trig_q;

    // R7: at most one source is claimed per access
    a_r7_claim_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_o));

    // R7: a claimed source must be pending when taken
    a_r7_claim_pending: assert property (@(posedge clk) disable iff (rst)
        (claim_o != '0) |-> ((claim_o & pend_i) == claim_o));

endmodule

// File: rtl/intc_platform.sv
module intc_platform #(
    parameter int N_SRC  = intc_pkg::DEF_N_SRC,
    parameter int N_CTX  = intc_pkg::DEF_N_CTX,
    parameter int PRIO_W = intc_pkg::DEF_PRIO_W,
    parameter int ADDR_W = intc_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_CTX-1:0]  irq_o
);
    localparam int ID_W = $clog2(N_SRC);

    logic [N_SRC-1:0]  pend_vec;
    logic [N_SRC-1:0]  edge_vec;
    logic [N_SRC-1:0]  claim_vec;
    logic [N_SRC-1:0]  done_vec;
    logic [PRIO_W-1:0] prio_arr [N_SRC];
    logic [N_SRC-1:0]  en_arr [N_CTX];
    logic [PRIO_W-1:0] thr_arr [N_CTX];
    logic [ID_W-1:0]   best_arr [N_CTX];
    logic [3:0]        unused_id0;

    // ID 0 is reserved: its request line and strobes go nowhere
    assign unused_id0 = {src_i[0], edge_vec[0], claim_vec[0], done_vec[0]};

    intc_regbank #(
        .N_SRC (N_SRC),
        .N_CTX (N_CTX),
        .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .pend_i    (pend_vec),
        .best_id_i (best_arr),
        .prio_o    (prio_arr),
        .en_o      (en_arr),
        .thr_o     (thr_arr),
        .edge_o    (edge_vec),
        .claim_o   (claim_vec),
        .complete_o(done_vec)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (s == 0) begin : g_rsvd
            assign pend_vec[s] = 1'b0;
        end else begin : g_gw
            intc_gateway u_gw (
                .clk       (clk),
                .rst       (rst),
                .src_i     (src_i[s]),
                .edge_i    (edge_vec[s]),
                .claim_i   (claim_vec[s]),
                .complete_i(done_vec[s]),
                .pend_o    (pend_vec[s])
            );
        end
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        intc_arbiter #(
            .N_SRC (N_SRC),
            .PRIO_W(PRIO_W),
            .ID_W  (ID_W)
        ) u_arb (
            .clk   (clk),
            .rst   (rst),
            .pend_i(pend_vec),
            .en_i  (en_arr[c]),
            .prio_i(prio_arr),
            .thr_i (thr_arr[c]),
            .id_o  (best_arr[c]),
            .irq_o (irq_o[c])
        );

        // R12: a context line needs a pending source enabled for that context
        a_r12_ctx_routing: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] |-> ((pend_vec & en_arr[c]) != '0));
    end

endmodule

// File: tb/tb_intc_platform.sv
module tb_intc_platform;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC  = 32;
    localparam int N_CTX  = 2;
    localparam int ADDR_W = 22;

    localparam logic [31:0] A_PEND = 32'h1000;
    localparam logic [31:0] A_TRIG = 32'h1080;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  src = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [N_CTX-1:0]  irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_platform #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(3), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wr(wr),
        .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] a_prio(int id); return 32'(4 * id); endfunction
    function automatic logic [31:0] a_en(int c); return 32'h2000 + 32'(c * 'h80); endfunction
    function automatic logic [31:0] a_thr(int c); return 32'h200000 + 32'(c * 'h1000); endfunction
    function automatic logic [31:0] a_clm(int c); return 32'h200004 + 32'(c * 'h1000); endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pend_bit(int id, output logic [31:0] b);
        logic [31:0] d;
        brd(A_PEND, d);
        b = 32'((d >> id) & 1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 0);
        brd(a_prio(5), d);  chk("R1 prio", d, 0);
        brd(A_PEND, d);     chk("R1 pend", d, 0);
        brd(a_thr(1), d);   chk("R1 thr", d, 0);
        brd(a_clm(0), d);   chk("R1 claim", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bwr(a_prio(3), 32'hFFFF_FFFF); brd(a_prio(3), d); chk("R2 prio width", d, 7);
        bwr(a_prio(0), 5);             brd(a_prio(0), d); chk("R2 id0 prio", d, 0);
        bwr(a_en(0), 32'hFFFF_FFFF);   brd(a_en(0), d);   chk("R4 enable bit0", d, 32'hFFFF_FFFE);
        brd(a_en(1), d);                                  chk("R4 ctx1 separate", d, 0);
        bwr(a_thr(0), 32'h1F);         brd(a_thr(0), d);  chk("R5 thr width", d, 7);
        bwr(a_en(0), 0); bwr(a_prio(3), 0); bwr(a_thr(0), 0);
    endtask

    task automatic t_pend();
        logic [31:0] d, b;
        bwr(a_prio(4), 2);
        src[4] = 1'b1; tick(2);
        pend_bit(4, b); chk("R3 pend while disabled", b, 1);
        chk("R3 irq off when disabled", 32'(irq[0]), 0);
        bwr(A_PEND, 0);
        pend_bit(4, b); chk("R3 pend write ignored", b, 1);
        bwr(a_en(0), 32'h10);
        chk("R5 irq raised", 32'(irq[0]), 1);
        brd(a_clm(0), d); chk("R7 claim id", d, 4);
        pend_bit(4, b); chk("R7 claim clears pend", b, 0);
        chk("R7 irq drops", 32'(irq[0]), 0);
        tick(3);
        pend_bit(4, b); chk("R8 no repend in service", b, 0);
        bwr(a_clm(0), 4); tick(2);
        pend_bit(4, b); chk("R8 repend after complete", b, 1);
        src[4] = 1'b0;
        brd(a_clm(0), d); chk("R8 reclaim", d, 4);
        bwr(a_clm(0), 4); tick(2);
        pend_bit(4, b); chk("R8 idle after drop", b, 0);
        bwr(a_en(0), 0);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        bwr(a_prio(6), 3); bwr(a_en(0), 32'h40); bwr(a_thr(0), 3);
        src[6] = 1'b1; tick(2);
        chk("R5 equal prio masked", 32'(irq[0]), 0);
        brd(a_clm(0), d); chk("R7 empty claim", d, 0);
        bwr(a_thr(0), 2);
        chk("R5 above thr", 32'(irq[0]), 1);
        bwr(a_prio(6), 7); bwr(a_thr(0), 7);
        chk("R5 thr7 masks", 32'(irq[0]), 0);
        bwr(a_thr(0), 0); bwr(a_prio(6), 0);
        chk("R5 prio0 never", 32'(irq[0]), 0);
        bwr(a_prio(6), 3);
        chk("R5 restored", 32'(irq[0]), 1);
        brd(a_clm(0), d); chk("R7 claim 6", d, 6);
        src[6] = 1'b0;
        bwr(a_clm(0), 6);
        bwr(a_en(0), 0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        bwr(a_prio(5), 5); bwr(a_prio(9), 2); bwr(a_prio(12), 5);
        bwr(a_en(0), 32'h0000_1220);
        src[5] = 1'b1; src[9] = 1'b1; src[12] = 1'b1; tick(1);
        src[5] = 1'b0; src[9] = 1'b0; src[12] = 1'b0; tick(1);
        brd(a_clm(0), d); chk("R6 tie low id", d, 5);
        brd(a_clm(0), d); chk("R6 next of tie", d, 12);
        brd(a_clm(0), d); chk("R6 lower prio last", d, 9);
        brd(a_clm(0), d); chk("R7 drained", d, 0);
        bwr(a_clm(0), 5); bwr(a_clm(0), 12); bwr(a_clm(0), 9);
        bwr(a_en(0), 0);
    endtask

    task automatic t_edge();
        logic [31:0] d, b;
        bwr(A_TRIG, 32'h0000_0401);
        brd(A_TRIG, d); chk("R10 trig readback", d, 32'h400);
        bwr(a_prio(10), 1); bwr(a_en(0), 32'h400);
        src[10] = 1'b1; tick(2);
        brd(a_clm(0), d); chk("R9 edge claim", d, 10);
        tick(2);
        bwr(a_clm(0), 10); tick(2);
        pend_bit(10, b); chk("R9 held high no repend", b, 0);
        src[10] = 1'b0; tick(1); src[10] = 1'b1; tick(2);
        brd(a_clm(0), d); chk("R9 new edge claim", d, 10);
        src[10] = 1'b0; tick(1); src[10] = 1'b1; tick(1);
        src[10] = 1'b0; tick(1); src[10] = 1'b1; tick(1);
        pend_bit(10, b); chk("R9 deferred hidden", b, 0);
        bwr(a_clm(0), 10); tick(1);
        pend_bit(10, b); chk("R9 deferred pends", b, 1);
        brd(a_clm(0), d); chk("R9 deferred claim", d, 10);
        bwr(a_clm(0), 10); tick(2);
        pend_bit(10, b); chk("R9 single event", b, 0);
        src[10] = 1'b0;
        bwr(a_en(0), 0);
    endtask

    task automatic t_badcomp();
        logic [31:0] d, b;
        bwr(a_prio(7), 1); bwr(a_en(0), 32'h80);
        src[7] = 1'b1; tick(2);
        brd(a_clm(0), d); chk("R11 setup claim", d, 7);
        bwr(a_clm(0), 8); bwr(a_clm(0), 0); tick(2);
        pend_bit(7, b); chk("R11 stray complete ignored", b, 0);
        bwr(a_clm(0), 7); tick(2);
        pend_bit(7, b); chk("R11 true complete", b, 1);
        src[7] = 1'b0;
        brd(a_clm(0), d); bwr(a_clm(0), 7);
        bwr(a_en(0), 0);
    endtask

    task automatic t_ctx();
        logic [31:0] d;
        bwr(a_prio(3), 4); bwr(a_en(1), 32'h8); bwr(a_thr(1), 0);
        src[3] = 1'b1; tick(2);
        chk("R12 ctx0 quiet", 32'(irq[0]), 0);
        chk("R12 ctx1 raised", 32'(irq[1]), 1);
        bwr(a_thr(1), 4);
        chk("R12 ctx1 thr mask", 32'(irq[1]), 0);
        bwr(a_thr(1), 3);
        brd(a_clm(0), d); chk("R12 ctx0 cannot claim", d, 0);
        brd(a_clm(1), d); chk("R12 ctx1 claim", d, 3);
        src[3] = 1'b0;
        bwr(a_clm(1), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_pend();
        t_thresh();
        t_arb();
        t_edge();
        t_badcomp();
        t_ctx();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule